// File: doc/BRIEF.md
# Pre-adder Multiplier Input Stage

This block is the front half of a pipelined arithmetic slice. It accepts a 30-bit operand A, an 18-bit operand B and a 25-bit operand D. In multiply mode it first combines D with the low 25 bits of A in a 25-bit pre-adder, then forms the signed 25x18 product and sign-extends it to 48 bits. In concatenate mode it skips the arithmetic and hands A and B onward as one 48-bit word. Either way the next stage (an adder or accumulator outside this block) receives a 48-bit value.

Each operand and the control word pass through a chain of optional input registers, zero to two deep, chosen by parameter. A product register and an output register follow. Multiply and concatenate travel through the same registers, so a mode change never shifts output timing. Every register group has its own clock enable and its own synchronous reset, and reset takes precedence over the clock enable.

Top module: `preadd_mul_stage`

## Requirements
- R1: In multiply mode (`mode_cat`=0) `p_out` equals the signed product of the 25-bit pre-adder result and signed B, sign-extended to 48 bits.
- R2: The pre-adder, selected by `pre_op`, yields A[24:0] for 2'b00, A[24:0]+D for 2'b01, A[24:0]-D for 2'b10 and D alone for 2'b11; the result wraps modulo 2^25 and is treated as signed.
- R3: In concatenate mode (`mode_cat`=1) `p_out` equals {A[29:0], B[17:0]}, with A in bits 47:18, and D and `pre_op` have no effect on it.
- R4: With all clock enables high, a change on A, B, D or the mode/op inputs reaches `p_out` after exactly STAGES+2 rising edges for its own chain (A_STAGES, B_STAGES, D_STAGES, CTL_STAGES), in both modes alike.
- R5: A register group whose clock enable is low keeps its value; `ce_a`/`ce_b` bit 0 drives the first and bit 1 the second input stage; `ce_p` low freezes `p_out`.
- R6: A group's reset clears it to zero at the next rising edge even when its clock enable is high.
- R7: After all resets, `p_out` is zero.
- R8: In multiply mode bits 29:25 of A have no effect on `p_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| a_in | input | 30 | Operand A |
| b_in | input | 18 | Operand B |
| d_in | input | 25 | Pre-adder operand D |
| mode_cat | input | 1 | 0 multiply, 1 concatenate |
| pre_op | input | 2 | Pre-adder operation select |
| ce_a | input | 2 | Clock enables, A stages 1 and 2 |
| ce_b | input | 2 | Clock enables, B stages 1 and 2 |
| ce_d | input | 1 | Clock enable, D stages |
| ce_ctl | input | 1 | Clock enable, mode/op stages |
| ce_m | input | 1 | Clock enable, product register |
| ce_p | input | 1 | Clock enable, output register |
| rst_a | input | 1 | Synchronous reset, A stages |
| rst_b | input | 1 | Synchronous reset, B stages |
| rst_d | input | 1 | Synchronous reset, D stages |
| rst_ctl | input | 1 | Synchronous reset, mode/op stages |
| rst_m | input | 1 | Synchronous reset, product register |
| rst_p | input | 1 | Synchronous reset, output register |
| p_out | output | 48 | Result to the next stage |

## Verification
The hold and product-register checks assume each register group is reset once before its enable is first dropped. They also assume the operand widths meet the default relation A+B=48 with D as wide as the multiplier's A port. The stimulus raises every reset together for the first cycles and only changes widths by parameter in ways that keep that relation. The random phase holds all enables high so that latency per stage setting can be read directly from the output stream. Enables and resets are then toggled one group at a time in directed steps, so that each step isolates one register group.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [1:0] {
    PRE_A   = 2'b00,
    PRE_ADD = 2'b01,
    PRE_SUB = 2'b10,
    PRE_D   = 2'b11
  } pms_preop_e;

  typedef struct packed {
    logic       cat;
    pms_preop_e op;
  } pms_ctl_t;

endpackage

// File: rtl/pms_reg.sv
module pms_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ce)  q <= d;
  end

  // R6: reset clears regardless of enable
  p_rst_clear_r6: assert property (@(posedge clk) rst |=> (q == '0));

  // R5: enable low holds the value
  p_hold_r5: assert property (@(posedge clk) disable iff (rst) !ce |=> $stable(q));

endmodule

// File: rtl/pms_pipe.sv
module pms_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter int CE_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CE_W-1:0] ce,
  input  logic [W-1:0]    d,
  output logic [W-1:0]    q
);

  logic [W-1:0] s [STAGES+1];

  assign s[0] = d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      pms_reg #(.W(W)) u_reg (
        .clk (clk),
        .rst (rst),
        .ce  (ce[i]),
        .d   (s[i]),
        .q   (s[i+1])
      );
    end
  endgenerate

  assign q = s[STAGES];

endmodule

// File: rtl/pms_arith.sv
module pms_arith
  import pms_pkg::*;
#(
  parameter int A_W  = 30,
  parameter int B_W  = 18,
  parameter int MA_W = 25,
  parameter int P_W  = 48
) (
  input  logic [A_W-1:0]  a,
  input  logic [B_W-1:0]  b,
  input  logic [MA_W-1:0] d,
  input  pms_ctl_t        ctl,
  output logic [MA_W-1:0] pre_sum,
  output logic [P_W-1:0]  m_next
);

  localparam int PROD_W = MA_W + B_W;
  localparam int EXT_W  = P_W - PROD_W;

  function automatic logic [MA_W-1:0] f_preadd(pms_preop_e op,
                                               logic [MA_W-1:0] al,
                                               logic [MA_W-1:0] dv);
    logic [MA_W-1:0] r;
    case (op)
      PRE_ADD: r = al + dv;
      PRE_SUB: r = al - dv;
      PRE_D:   r = dv;
      default: r = al;
    endcase
    return r;
  endfunction

  function automatic logic [P_W-1:0] f_mul_ext(logic [MA_W-1:0] x,
                                               logic [B_W-1:0]  y);
    logic signed [PROD_W-1:0] pr;
    pr = $signed(x) * $signed(y);
    return {{EXT_W{pr[PROD_W-1]}}, pr};
  endfunction

  logic [P_W-1:0] prod_ext;

  always_comb begin
    pre_sum  = f_preadd(ctl.op, a[MA_W-1:0], d);
    prod_ext = f_mul_ext(pre_sum, b);
    m_next   = ctl.cat ? {a, b} : prod_ext;
  end

endmodule

// File: rtl/preadd_mul_stage.sv
module preadd_mul_stage
  import pms_pkg::*;
#(
  parameter int A_W        = 30,
  parameter int B_W        = 18,
  parameter int MA_W       = 25,
  parameter int A_STAGES   = 2,
  parameter int B_STAGES   = 2,
  parameter int D_STAGES   = 2,
  parameter int CTL_STAGES = 2
) (
  input  logic                 clk,
  input  logic [A_W-1:0]       a_in,
  input  logic [B_W-1:0]       b_in,
  input  logic [MA_W-1:0]      d_in,
  input  logic                 mode_cat,
  input  logic [1:0]           pre_op,
  input  logic [1:0]           ce_a,
  input  logic [1:0]           ce_b,
  input  logic                 ce_d,
  input  logic                 ce_ctl,
  input  logic                 ce_m,
  input  logic                 ce_p,
  input  logic                 rst_a,
  input  logic                 rst_b,
  input  logic                 rst_d,
  input  logic                 rst_ctl,
  input  logic                 rst_m,
  input  logic                 rst_p,
  output logic [A_W+B_W-1:0]   p_out
);

  localparam int P_W    = A_W + B_W;
  localparam int PROD_W = MA_W + B_W;
  localparam int CTL_W  = $bits(pms_ctl_t);

  logic [A_W-1:0]   a_st;
  logic [B_W-1:0]   b_st;
  logic [MA_W-1:0]  d_st;
  logic [CTL_W-1:0] ctl_in_v, ctl_st_v;
  pms_ctl_t         ctl_in, ctl_st;
  logic [MA_W-1:0]  pre_sum;
  logic [P_W-1:0]   m_next, m_q, p_q;
  logic             ctl_cat;

  assign ctl_in.cat = mode_cat;
  assign ctl_in.op  = pms_preop_e'(pre_op);
  assign ctl_in_v   = ctl_in;
  assign ctl_st     = pms_ctl_t'(ctl_st_v);
  assign ctl_cat    = ctl_st.cat;

  pms_pipe #(.W(A_W), .STAGES(A_STAGES)) u_a_pipe (
    .clk(clk), .rst(rst_a), .ce(ce_a), .d(a_in), .q(a_st));

  pms_pipe #(.W(B_W), .STAGES(B_STAGES)) u_b_pipe (
    .clk(clk), .rst(rst_b), .ce(ce_b), .d(b_in), .q(b_st));

  pms_pipe #(.W(MA_W), .STAGES(D_STAGES)) u_d_pipe (
    .clk(clk), .rst(rst_d), .ce({ce_d, ce_d}), .d(d_in), .q(d_st));

  pms_pipe #(.W(CTL_W), .STAGES(CTL_STAGES)) u_ctl_pipe (
    .clk(clk), .rst(rst_ctl), .ce({ce_ctl, ce_ctl}), .d(ctl_in_v), .q(ctl_st_v));

  pms_arith #(.A_W(A_W), .B_W(B_W), .MA_W(MA_W), .P_W(P_W)) u_arith (
    .a(a_st), .b(b_st), .d(d_st), .ctl(ctl_st),
    .pre_sum(pre_sum), .m_next(m_next));

  pms_reg #(.W(P_W)) u_m_reg (
    .clk(clk), .rst(rst_m), .ce(ce_m), .d(m_next), .q(m_q));

  pms_reg #(.W(P_W)) u_p_reg (
    .clk(clk), .rst(rst_p), .ce(ce_p), .d(m_q), .q(p_q));

  assign p_out = p_q;

  // R1: a product loaded into M is sign-extended across the top bits
  p_mul_sext_r1: assert property (@(posedge clk) disable iff (rst_m)
    (ce_m && !ctl_cat) |=>
      ((m_q[P_W-1:PROD_W-1] == '0) || (&m_q[P_W-1:PROD_W-1])));

  // R3: concatenate mode places staged A high and staged B low
  p_cat_upper_r3: assert property (@(posedge clk) disable iff (rst_m)
    (ce_m && ctl_cat) |=> (m_q[P_W-1:B_W] == $past(a_st)));
  p_cat_lower_r3: assert property (@(posedge clk) disable iff (rst_m)
    (ce_m && ctl_cat) |=> (m_q[B_W-1:0] == $past(b_st)));

  // R2: bypass encodings pass the selected operand through the pre-adder
  p_pre_bypass_r2: assert property (@(posedge clk) disable iff (rst_ctl)
    (ctl_st.op == PRE_A) |-> (pre_sum == a_st[MA_W-1:0]));
  p_pre_donly_r2: assert property (@(posedge clk) disable iff (rst_ctl)
    (ctl_st.op == PRE_D) |-> (pre_sum == d_st));

  // R4: output register takes the product register one edge later
  p_out_follows_r4: assert property (@(posedge clk) disable iff (rst_p)
    ce_p |=> (p_q == $past(m_q)));

endmodule

// File: tb/preadd_mul_stage_bench.sv
`timescale 1ns/1ps
module preadd_mul_stage_bench;

  logic        clk = 1'b0;
  logic [29:0] a_in;
  logic [17:0] b_in;
  logic [24:0] d_in;
  logic        mode_cat;
  logic [1:0]  pre_op;
  logic [1:0]  ce_a, ce_b;
  logic        ce_d, ce_ctl, ce_m, ce_p;
  logic        rst_a, rst_b, rst_d, rst_ctl, rst_m, rst_p;
  logic [47:0] p_out, p_out_s0, p_out_s1;

  int checks = 0;
  int errors = 0;
  logic [47:0] hist [8];

  always #2.5 clk = ~clk;

  preadd_mul_stage u_preadd_mul_stage (
    .clk, .a_in, .b_in, .d_in, .mode_cat, .pre_op, .ce_a, .ce_b, .ce_d,
    .ce_ctl, .ce_m, .ce_p, .rst_a, .rst_b, .rst_d, .rst_ctl, .rst_m, .rst_p,
    .p_out(p_out));

  preadd_mul_stage #(.A_STAGES(0), .B_STAGES(0), .D_STAGES(0), .CTL_STAGES(0))
  u_preadd_mul_stage_s0 (
    .clk, .a_in, .b_in, .d_in, .mode_cat, .pre_op, .ce_a, .ce_b, .ce_d,
    .ce_ctl, .ce_m, .ce_p, .rst_a, .rst_b, .rst_d, .rst_ctl, .rst_m, .rst_p,
    .p_out(p_out_s0));

  preadd_mul_stage #(.A_STAGES(1), .B_STAGES(1), .D_STAGES(1), .CTL_STAGES(1))
  u_preadd_mul_stage_s1 (
    .clk, .a_in, .b_in, .d_in, .mode_cat, .pre_op, .ce_a, .ce_b, .ce_d,
    .ce_ctl, .ce_m, .ce_p, .rst_a, .rst_b, .rst_d, .rst_ctl, .rst_m, .rst_p,
    .p_out(p_out_s1));

  function automatic longint sx(longint v, int w);
    longint m = longint'(1) << w;
    v = v % m;
    if (v < 0) v += m;
    if (v >= (m >> 1)) v -= m;
    return v;
  endfunction

  function automatic logic [47:0] model(logic [29:0] a, logic [17:0] b,
                                        logic [24:0] d, logic cat, logic [1:0] op);
    longint av, dv, bv, s, pr;
    if (cat) return {a, b};
    av = sx(longint'(a[24:0]), 25);
    dv = sx(longint'(d), 25);
    bv = sx(longint'(b), 18);
    if (op == 2'd1)      s = av + dv;
    else if (op == 2'd2) s = av - dv;
    else if (op == 2'd3) s = dv;
    else                 s = av;
    s  = sx(s, 25);
    pr = s * bv;
    return pr[47:0];
  endfunction

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [29:0] a, logic [17:0] b, logic [24:0] d,
                       logic cat, logic [1:0] op);
    a_in = a; b_in = b; d_in = d; mode_cat = cat; pre_op = op;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_ce(logic v);
    ce_a = {v, v}; ce_b = {v, v}; ce_d = v; ce_ctl = v; ce_m = v; ce_p = v;
  endtask

  task automatic all_rst(logic v);
    rst_a = v; rst_b = v; rst_d = v; rst_ctl = v; rst_m = v; rst_p = v;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [29:0] ra;
    logic [17:0] rb;
    logic [24:0] rd;
    logic        rc;
    logic [1:0]  ro;
    logic [47:0] e_old;
    void'($urandom(32'h00c0ffee));
    drive('0, '0, '0, 1'b0, 2'b00);
    all_ce(1'b1);
    all_rst(1'b1);
    wait_n(3);
    all_rst(1'b0);
    // R7: output cleared after reset
    chk("R7 reset", p_out, 48'h0);
    chk("R7 reset s0", p_out_s0, 48'h0);

    // R1 R2 R3 R4: random stream, latency 2/3/4 per stage setting
    for (int i = 0; i < 8; i++) hist[i] = 48'h0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (k >= 2) chk("R4 latency stages=0", p_out_s0, hist[(k-2)%8]);
      if (k >= 3) chk("R4 latency stages=1", p_out_s1, hist[(k-3)%8]);
      if (k >= 4) chk("R1 R2 R3 R4 stages=2", p_out, hist[(k-4)%8]);
      ra = $urandom; rb = 18'($urandom); rd = 25'($urandom);
      rc = ($urandom % 3) == 0; ro = 2'($urandom);
      case ($urandom % 8)
        0: begin ra[24:0] = 25'h1000000; rb = 18'h20000; ro = 2'd0; end
        1: begin ra[24:0] = 25'h0FFFFFF; rd = 25'h1; ro = 2'd1; end
        2: begin ra[24:0] = 25'h1000000; rd = 25'h1; ro = 2'd2; end
        default: ;
      endcase
      drive(ra, rb, rd, rc, ro);
      hist[k%8] = model(ra, rb, rd, rc, ro);
    end

    // R2: wrap of A+D at the positive limit
    drive(30'h0FFFFFF, 18'h1, 25'h1, 1'b0, 2'b01);
    wait_n(6);
    chk("R2 wrap", p_out, 48'hFFFF_FF00_0000);
    // R2: D only
    drive(30'h123, 18'h3, 25'h1FFFFFE, 1'b0, 2'b11);
    wait_n(6);
    chk("R2 d only", p_out, 48'hFFFF_FFFF_FFFA);

    // R8: upper A bits ignored in multiply mode
    drive(30'h3E000005, 18'h7, 25'h0, 1'b0, 2'b00);
    wait_n(6);
    chk("R8 upper A", p_out, 48'd35);

    // R3: D and op ignored in concatenate mode
    drive(30'h2AAAAAAA, 18'h15555, 25'h1ABCDEF, 1'b1, 2'b01);
    wait_n(6);
    e_old = {30'h2AAAAAAA, 18'h15555};
    chk("R3 concat", p_out, e_old);
    drive(30'h2AAAAAAA, 18'h15555, 25'h0000123, 1'b1, 2'b10);
    wait_n(6);
    chk("R3 concat d ignored", p_out, e_old);

    // R5: A enables low hold A
    drive(30'h10, 18'h3, 25'h0, 1'b0, 2'b00);
    wait_n(6);
    chk("R5 setup", p_out, 48'd48);
    ce_a = 2'b00;
    a_in = 30'h20;
    wait_n(6);
    chk("R5 ce_a low", p_out, 48'd48);
    ce_a = 2'b01;
    wait_n(6);
    chk("R5 ce_a stage2 low", p_out, 48'd48);
    ce_a = 2'b11;
    wait_n(6);
    chk("R5 ce_a restored", p_out, 48'd96);
    // R5: output enable low freezes output
    ce_p = 1'b0;
    b_in = 18'h5;
    wait_n(6);
    chk("R5 ce_p low", p_out, 48'd96);
    ce_p = 1'b1;
    wait_n(2);
    chk("R5 ce_p restored", p_out, 48'd160);

    // R6: reset wins over enable on the output register
    rst_p = 1'b1;
    @(negedge clk);
    chk("R6 rst_p", p_out, 48'h0);
    rst_p = 1'b0;
    // R6: reset on the product register propagates zero
    rst_m = 1'b1;
    wait_n(3);
    chk("R6 rst_m", p_out, 48'h0);
    rst_m = 1'b0;
    // R6: reset on A chain in concatenate mode leaves only B
    drive(30'h3FFFFFFF, 18'h2BCDE, 25'h0, 1'b1, 2'b00);
    rst_a = 1'b1;
    wait_n(6);
    chk("R6 rst_a", p_out, {30'h0, 18'h2BCDE});
    rst_a = 1'b0;
    wait_n(6);
    chk("R6 rst_a released", p_out, {30'h3FFFFFFF, 18'h2BCDE});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule